// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading translation entries from memory. A request enters through a valid/ready handshake. If translation is turned on, the walker fetches one word from a per-context root table and then follows pointer entries through up to three further table levels. The walk stops at the first leaf entry. A leaf at the first or second level maps a large region, so the walk can end early. One response comes back with the physical address, the leaf entry with its level, permission and modified bit, or a fault code.

Memory is reached through one 32-bit word port. It holds a request until the memory raises ready. When a leaf still lacks its referenced mark, or a write reaches a leaf whose modified mark is clear, the walker sets those bits and writes the entry back to the address it was read from. Checking permissions and caching results are left to the logic around the block.

Top module: `va_walker`

## Requirements
- R1: With `mmu_en` low when a request is accepted, the response carries `rsp_pa` = {4'b0, va}, no fault, `rsp_entry` 0 and `rsp_level` 0. No memory access is made for that request.
- R2: With `mmu_en` high, the first read goes to `ctx_root`*16 + `ctx_num`*4.
- R3: Bits 1:0 of each fetched entry give its kind: 0 invalid, 1 pointer, 2 leaf, 3 reserved. For a pointer read at level L (0 to 2), the next read goes to (entry with bits 1:0 cleared)*16 + 4*index. The index is va[31:24] for level 1, va[23:18] for level 2 and va[17:12] for level 3.
- R4: A leaf read at level 1, 2 or 3 gives `rsp_pa` = entry[31:8]*4096 + va[23:0], va[17:0] or va[11:0] respectively. `rsp_level` is that level and `rsp_fault` is low.
- R5: A fault sets `rsp_fault`. `rsp_fault_code` carries the level of the faulting read in bits 9:8 and the kind in bits 4:2, with all other bits zero. The kind is 1 for an invalid entry. On a fault, `rsp_pa` is 0, `rsp_entry` is the offending entry and `rsp_level` is the faulting level.
- R6: Kind 4 is reported for a reserved entry, for a leaf at level 0, and for a pointer at level 3.
- R7: The referenced bit is entry bit 5 and the modified bit is entry bit 6. A leaf triggers one write to its own address when bit 5 is clear, or when the request is a write and bit 6 is clear. The written word is the leaf with bit 5 set, plus bit 6 for a write. No write occurs otherwise.
- R8: One request at a time. `req_ready` is high only while idle. The response stays valid and stable until `rsp_ready`. A walk makes at most four reads and one write.
- R9: `rsp_entry` is the leaf as it stands after any update. `rsp_perm` equals `rsp_entry[4:2]` and `rsp_modified` equals `rsp_entry[6]`.
- R10: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady from the cycle a memory access is raised until the cycle `mem_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmu_en | input | 1 | Translation on when high, sampled at request accept |
| ctx_root | input | 32 | Root table pointer (byte address / 16) |
| ctx_num | input | CTX_W | Context number indexing the root table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and accepting |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a store |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_fault_code | output | 10 | Level in 9:8, fault kind in 4:2 |
| rsp_pa | output | 36 | Physical address |
| rsp_entry | output | 32 | Leaf (updated) or offending entry |
| rsp_level | output | 2 | Level where the walk ended |
| rsp_perm | output | 3 | Leaf permission field |
| rsp_modified | output | 1 | Leaf modified mark |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 36 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |

## Verification
A request is accepted at the clock edge where `req_valid` and `req_ready` are both high. A bypassed request shows `rsp_valid` one cycle later. Each memory access finishes at the edge where `mem_ready` is high, and the walker raises the next access, or `rsp_valid`, in the cycle after that edge. The bench's memory model grants accesses after a chosen latency and compares each one with the list of accesses its own walk predicted. The response fields are checked at the first falling edge on which `rsp_valid` is seen, and again on every held cycle while `rsp_ready` is kept low. On every falling edge `req_ready` is compared with the bench's own idle flag.

// File: rtl/walk_pkg.sv
package walk_pkg;

  localparam int VA_W    = 32;
  localparam int PTE_W   = 32;
  localparam int PA_W    = 36;
  localparam int FC_W    = 10;
  localparam int REF_BIT = 5;
  localparam int MOD_BIT = 6;

  typedef enum logic [1:0] {
    ET_INVALID  = 2'd0,
    ET_POINTER  = 2'd1,
    ET_LEAF     = 2'd2,
    ET_RESERVED = 2'd3
  } etype_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_UPDATE,
    ST_RESP
  } wstate_t;

  localparam logic [2:0] FT_INVALID = 3'd1;
  localparam logic [2:0] FT_BADTYPE = 3'd4;

  function automatic logic [FC_W-1:0] make_fault(input logic [1:0] lvl, input logic [2:0] ft);
    return {lvl, 3'b000, ft, 2'b00};
  endfunction

  // Table base from the pointer field (entry bits 31:2), scaled by 64.
  function automatic logic [PA_W-1:0] table_base(input logic [29:0] ptr_hi);
    return {ptr_hi, 6'b000000};
  endfunction

  // Byte offset inside the table read at level lvl_n (1..3).
  function automatic logic [PA_W-1:0] index_off(input logic [VA_W-1:0] va, input logic [1:0] lvl_n);
    case (lvl_n)
      2'd1:    return {26'b0, va[31:24], 2'b00};
      2'd2:    return {28'b0, va[23:18], 2'b00};
      default: return {28'b0, va[17:12], 2'b00};
    endcase
  endfunction

  // Offset inside the region mapped by a leaf at level lvl.
  function automatic logic [PA_W-1:0] leaf_offset(input logic [VA_W-1:0] va, input logic [1:0] lvl);
    case (lvl)
      2'd1:    return {12'b0, va[23:0]};
      2'd2:    return {18'b0, va[17:0]};
      default: return {24'b0, va[11:0]};
    endcase
  endfunction

endpackage

// File: rtl/walk_decode.sv
module walk_decode
  import walk_pkg::*;
(
  input  logic [1:0] lvl,
  input  logic [1:0] etype,
  output logic       go_next,
  output logic       go_leaf,
  output logic       go_fault,
  output logic [2:0] ftype
);

  always_comb begin
    go_next  = 1'b0;
    go_leaf  = 1'b0;
    go_fault = 1'b0;
    ftype    = 3'd0;
    case (etype_t'(etype))
      ET_INVALID: begin
        go_fault = 1'b1;
        ftype    = FT_INVALID;
      end
      ET_POINTER: begin
        if (lvl == 2'd3) begin
          go_fault = 1'b1;
          ftype    = FT_BADTYPE;
        end else begin
          go_next = 1'b1;
        end
      end
      ET_LEAF: begin
        if (lvl == 2'd0) begin
          go_fault = 1'b1;
          ftype    = FT_BADTYPE;
        end else begin
          go_leaf = 1'b1;
        end
      end
      default: begin
        go_fault = 1'b1;
        ftype    = FT_BADTYPE;
      end
    endcase
  end

endmodule

// File: rtl/walk_addr.sv
module walk_addr
  import walk_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic [31:0]      ctx_root,
  input  logic [CTX_W-1:0] ctx_num,
  input  logic [VA_W-1:0]  va,
  input  logic [29:0]      ptr_field,
  input  logic [23:0]      page_field,
  input  logic [1:0]       lvl,
  output logic [PA_W-1:0]  root_addr,
  output logic [PA_W-1:0]  next_addr,
  output logic [PA_W-1:0]  leaf_pa
);

  localparam int CTX_PAD = PA_W - CTX_W - 2;

  logic [PA_W-1:0] root_base;
  logic [PA_W-1:0] ctx_off;

  assign root_base = {ctx_root, 4'b0000};
  assign ctx_off   = {{CTX_PAD{1'b0}}, ctx_num, 2'b00};
  assign root_addr = root_base + ctx_off;

  assign next_addr = table_base(ptr_field) + index_off(va, lvl + 2'd1);
  assign leaf_pa   = {page_field, 12'b0} + leaf_offset(va, lvl);

endmodule

// File: rtl/walk_mark.sv
module walk_mark
  import walk_pkg::*;
(
  input  logic [PTE_W-1:0] entry,
  input  logic             is_write,
  output logic [PTE_W-1:0] marked,
  output logic             need_wb
);

  logic set_ref;
  logic set_mod;

  assign set_ref = ~entry[REF_BIT];
  assign set_mod = is_write & ~entry[MOD_BIT];
  assign need_wb = set_ref | set_mod;

  always_comb begin
    marked          = entry;
    marked[REF_BIT] = 1'b1;
    if (is_write) marked[MOD_BIT] = 1'b1;
  end

endmodule

// File: rtl/va_walker.sv
module va_walker
  import walk_pkg::*;
#(
  parameter int CTX_W  = 8,
  parameter int RD_MAX = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mmu_en,
  input  logic [31:0]      ctx_root,
  input  logic [CTX_W-1:0] ctx_num,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_va,
  input  logic             req_write,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_fault,
  output logic [9:0]       rsp_fault_code,
  output logic [35:0]      rsp_pa,
  output logic [31:0]      rsp_entry,
  output logic [1:0]       rsp_level,
  output logic [2:0]       rsp_perm,
  output logic             rsp_modified,
  output logic             mem_req,
  output logic             mem_we,
  output logic [35:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ready,
  input  logic [31:0]      mem_rdata
);

  wstate_t           state;
  logic [1:0]        lvl;
  logic [PA_W-1:0]   cur_addr;
  logic [VA_W-1:0]   va_q;
  logic              wr_q;
  logic [PTE_W-1:0]  res_entry;
  logic [PA_W-1:0]   res_pa;
  logic [1:0]        res_level;
  logic              res_fault;
  logic [FC_W-1:0]   res_code;

  // Named events for the assertions
  logic accept_fire, rd_fire, wr_fire, rsp_fire;

  logic go_next, go_leaf, go_fault;
  logic [2:0] ftype;
  logic [PA_W-1:0] root_addr, next_addr, leaf_pa;
  logic [PTE_W-1:0] marked;
  logic need_wb;

  assign req_ready   = (state == ST_IDLE);
  assign rsp_valid   = (state == ST_RESP);
  assign mem_req     = (state == ST_FETCH) || (state == ST_UPDATE);
  assign mem_we      = (state == ST_UPDATE);
  assign mem_addr    = cur_addr;
  assign mem_wdata   = res_entry;

  assign accept_fire = req_valid & req_ready;
  assign rd_fire     = (state == ST_FETCH) & mem_ready;
  assign wr_fire     = (state == ST_UPDATE) & mem_ready;
  assign rsp_fire    = rsp_valid & rsp_ready;

  assign rsp_fault      = res_fault;
  assign rsp_fault_code = res_code;
  assign rsp_pa         = res_pa;
  assign rsp_entry      = res_entry;
  assign rsp_level      = res_level;
  assign rsp_perm       = res_entry[4:2];
  assign rsp_modified   = res_entry[MOD_BIT];

  walk_decode u_decode (
    .lvl      (lvl),
    .etype    (mem_rdata[1:0]),
    .go_next  (go_next),
    .go_leaf  (go_leaf),
    .go_fault (go_fault),
    .ftype    (ftype)
  );

  walk_addr #(.CTX_W(CTX_W)) u_addr (
    .ctx_root   (ctx_root),
    .ctx_num    (ctx_num),
    .va         (va_q),
    .ptr_field  (mem_rdata[31:2]),
    .page_field (mem_rdata[31:8]),
    .lvl        (lvl),
    .root_addr  (root_addr),
    .next_addr  (next_addr),
    .leaf_pa    (leaf_pa)
  );

  walk_mark u_mark (
    .entry    (mem_rdata),
    .is_write (wr_q),
    .marked   (marked),
    .need_wb  (need_wb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lvl       <= 2'd0;
      cur_addr  <= '0;
      va_q      <= '0;
      wr_q      <= 1'b0;
      res_entry <= '0;
      res_pa    <= '0;
      res_level <= 2'd0;
      res_fault <= 1'b0;
      res_code  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept_fire) begin
            va_q      <= req_va;
            wr_q      <= req_write;
            lvl       <= 2'd0;
            res_entry <= '0;
            res_level <= 2'd0;
            res_fault <= 1'b0;
            res_code  <= '0;
            if (mmu_en) begin
              cur_addr <= root_addr;
              res_pa   <= '0;
              state    <= ST_FETCH;
            end else begin
              res_pa   <= {{(PA_W-VA_W){1'b0}}, req_va};
              state    <= ST_RESP;
            end
          end
        end
        ST_FETCH: begin
          if (mem_ready) begin
            if (go_next) begin
              cur_addr <= next_addr;
              lvl      <= lvl + 2'd1;
            end else if (go_leaf) begin
              res_entry <= marked;
              res_level <= lvl;
              res_pa    <= leaf_pa;
              state     <= need_wb ? ST_UPDATE : ST_RESP;
            end else begin
              res_entry <= mem_rdata;
              res_level <= lvl;
              res_fault <= 1'b1;
              res_code  <= make_fault(lvl, ftype);
              state     <= ST_RESP;
            end
          end
        end
        ST_UPDATE: begin
          if (mem_ready) state <= ST_RESP;
        end
        default: begin
          if (rsp_ready) state <= ST_IDLE;
        end
      endcase
    end
  end

  // Checker state kept apart from the datapath
  logic [2:0]      rd_cnt;
  logic [1:0]      wr_cnt;
  logic            bypass_q;
  logic [PA_W-1:0] last_rd_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt       <= '0;
      wr_cnt       <= '0;
      bypass_q     <= 1'b0;
      last_rd_addr <= '0;
    end else begin
      if (accept_fire) begin
        rd_cnt   <= '0;
        wr_cnt   <= '0;
        bypass_q <= ~mmu_en;
      end else begin
        if (rd_fire && rd_cnt != 3'd7) rd_cnt <= rd_cnt + 3'd1;
        if (wr_fire && wr_cnt != 2'd3) wr_cnt <= wr_cnt + 2'd1;
        if (rsp_fire) bypass_q <= 1'b0;
      end
      if (rd_fire) last_rd_addr <= mem_addr;
    end
  end

  assert_bypass_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_q |-> !mem_req);

  assert_decode_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |-> $onehot({go_next, go_leaf, go_fault}));

  assert_fault_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_fault_code[1:0] == 2'b00 && rsp_fault_code[7:5] == 3'b000 &&
      (rsp_fault_code[4:2] == FT_INVALID || rsp_fault_code[4:2] == FT_BADTYPE)));

  assert_wb_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (mem_addr == last_rd_addr && mem_wdata[REF_BIT]));

  assert_budget_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cnt <= 3'(RD_MAX)) && (wr_cnt <= 2'd1));

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_entry) &&
      $stable(rsp_fault_code) && $stable(rsp_level)));

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

endmodule

// File: tb/tb_va_walker.sv
module tb_va_walker;

  localparam int CLK_PERIOD = 10;
  localparam int CTX_W      = 8;
  localparam int WATCHDOG   = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mmu_en = 1'b0;
  logic [31:0] ctx_root = '0;
  logic [CTX_W-1:0] ctx_num = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_va = '0;
  logic req_write = 1'b0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic rsp_fault;
  logic [9:0] rsp_fault_code;
  logic [35:0] rsp_pa;
  logic [31:0] rsp_entry;
  logic [1:0] rsp_level;
  logic [2:0] rsp_perm;
  logic rsp_modified;
  logic mem_req, mem_we;
  logic [35:0] mem_addr;
  logic [31:0] mem_wdata;
  logic mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  va_walker #(.CTX_W(CTX_W)) dut (
    .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en), .ctx_root(ctx_root), .ctx_num(ctx_num),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_fault_code(rsp_fault_code), .rsp_pa(rsp_pa), .rsp_entry(rsp_entry),
    .rsp_level(rsp_level), .rsp_perm(rsp_perm), .rsp_modified(rsp_modified),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  int n_checks = 0;
  int n_fails  = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Bench memory and expected access list
  logic [31:0] mem [longint];
  longint q_addr [$];
  bit     q_we   [$];
  longint q_wd   [$];
  int     mem_lat = 0;
  int     wait_cnt = 0;

  function automatic longint rd_word(input longint a);
    if (mem.exists(a)) return longint'(mem[a]);
    return 0;
  endfunction

  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready = 1'b0;
      wait_cnt  = 0;
    end else if (mem_req && rst_n) begin
      if (wait_cnt >= mem_lat) begin
        if (q_addr.size() == 0) begin
          n_checks++; n_fails++;
          $display("FAIL R1/R8: unexpected access addr %0h expected none", mem_addr);
        end else begin
          check("R2/R3 access address", longint'(mem_addr), q_addr.pop_front());
          check("R7 access direction", longint'(mem_we), longint'(q_we.pop_front()));
          if (mem_we) check("R7 written word", longint'(mem_wdata), q_wd.pop_front());
          else void'(q_wd.pop_front());
        end
        if (mem_we) mem[longint'(mem_addr)] = mem_wdata;
        else mem_rdata = rd_word(longint'(mem_addr))[31:0];
        mem_ready = 1'b1;
      end else begin
        wait_cnt++;
      end
    end
  end

  // Per-clock comparison of the request side with the bench's own idle flag
  bit model_idle = 1'b1;
  bit mon_on = 1'b0;
  always @(negedge clk) begin
    if (mon_on) check("R8 req_ready follows idle", longint'(req_ready), longint'(model_idle));
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  // Behavioural reference walk
  longint e_pa, e_entry;
  int     e_level, e_code;
  bit     e_fault;

  task automatic ref_walk(input bit en, input longint va, input bit wr,
                          input longint root, input int ctx);
    longint a, e, ne;
    int t, sh;
    e_pa = 0; e_entry = 0; e_level = 0; e_code = 0; e_fault = 0;
    if (!en) begin
      e_pa = va;
      return;
    end
    a = root * 16 + ctx * 4;
    for (int lv = 0; lv < 4; lv++) begin
      e = rd_word(a);
      q_addr.push_back(a); q_we.push_back(1'b0); q_wd.push_back(0);
      t = int'(e % 4);
      if (t == 0 || t == 3 || (t == 1 && lv == 3) || (t == 2 && lv == 0)) begin
        e_fault = 1; e_entry = e; e_level = lv;
        e_code = lv * 256 + ((t == 0) ? 1 : 4) * 4;
        return;
      end
      if (t == 1) begin
        if (lv == 0)      a = (e / 4) * 64 + ((va >> 24) % 256) * 4;
        else if (lv == 1) a = (e / 4) * 64 + ((va >> 18) % 64) * 4;
        else              a = (e / 4) * 64 + ((va >> 12) % 64) * 4;
      end else begin
        sh = (lv == 1) ? 24 : (lv == 2) ? 18 : 12;
        e_pa = (e / 256) * 4096 + (va % (longint'(1) << sh));
        e_level = lv;
        ne = e;
        if ((e / 32) % 2 == 0 || (wr && (e / 64) % 2 == 0)) begin
          ne = e | 32 | (wr ? 64 : 0);
          q_addr.push_back(a); q_we.push_back(1'b1); q_wd.push_back(ne);
        end
        e_entry = ne;
        return;
      end
    end
  endtask

  task automatic run(input string tag, input bit en, input longint va, input bit wr,
                     input int ctx, input int lat, input int hold);
    int guard;
    mem_lat = lat;
    ref_walk(en, va, wr, longint'(ctx_root), ctx);
    @(negedge clk);
    mmu_en = en; req_va = va[31:0]; req_write = wr; ctx_num = ctx[CTX_W-1:0];
    req_valid = 1'b1;
    @(posedge clk);
    model_idle = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    for (int h = 0; h <= hold; h++) begin
      check({tag, " rsp_valid"}, longint'(rsp_valid), 1);
      check({tag, " R5 fault flag"}, longint'(rsp_fault), longint'(e_fault));
      check({tag, " R5 fault code"}, longint'(rsp_fault_code), longint'(e_code));
      check({tag, " R4 pa"}, longint'(rsp_pa), e_pa);
      check({tag, " R9 entry"}, longint'(rsp_entry), e_entry);
      check({tag, " R4 level"}, longint'(rsp_level), longint'(e_level));
      if (h == 0) begin
        check({tag, " R9 perm"}, longint'(rsp_perm), (e_entry >> 2) % 8);
        check({tag, " R9 modified"}, longint'(rsp_modified), (e_entry >> 6) % 2);
        check({tag, " R8 busy while responding"}, longint'(req_ready), 0);
      end
      if (h < hold) @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    model_idle = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check({tag, " R8 response released"}, longint'(rsp_valid), 0);
    check({tag, " R8 all accesses made"}, longint'(q_addr.size()), 0);
    q_addr.delete(); q_we.delete(); q_wd.delete();
  endtask

  initial begin
    // Tables: root table at 0x1000, level-1 at 0x2000, level-2 at 0x3000, level-3 at 0x4000
    ctx_root = 32'h100;
    mem[64'h100C] = 32'h0000_0201;
    mem[64'h1018] = 32'h0000_1232;
    mem[64'h101C] = 32'h0000_0003;
    mem[64'h2048] = 32'h0ABC_003E;
    mem[64'h2100] = 32'h0000_0301;
    mem[64'h2104] = 32'h0000_0003;
    mem[64'h3084] = 32'h1234_560A;
    mem[64'h3000] = 32'h0000_0401;
    mem[64'h3004] = 32'h0000_0007;
    mem[64'h4014] = 32'h0077_7766;
    mem[64'h401C] = 32'h0088_8802;
    mem[64'h4024] = 32'h0000_0005;

    repeat (3) @(negedge clk);
    check("reset req_ready", longint'(req_ready), 1);
    check("reset rsp_valid", longint'(rsp_valid), 0);
    check("reset mem_req", longint'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;

    run("R1 bypass",               1'b0, 64'h8765_4321, 1'b1, 3, 0, 0);
    run("R2 R4 16MB leaf read",    1'b1, 64'h1234_5678, 1'b0, 3, 0, 1);
    run("R7 16MB leaf write",      1'b1, 64'h12FF_0001, 1'b1, 3, 2, 0);
    run("R4 R7 256KB leaf ref",    1'b1, 64'h4084_5678, 1'b0, 3, 1, 0);
    run("R7 256KB no rewrite",     1'b1, 64'h4087_0FF0, 1'b0, 3, 0, 2);
    run("R4 4KB leaf marked",      1'b1, 64'h4000_5ABC, 1'b1, 3, 3, 0);
    run("R7 4KB write dirties",    1'b1, 64'h4000_7123, 1'b1, 3, 0, 0);
    run("R7 4KB now clean read",   1'b1, 64'h4000_7FFF, 1'b0, 3, 1, 0);
    run("R5 ctx invalid",          1'b1, 64'h1234_5678, 1'b0, 5, 0, 0);
    run("R6 ctx leaf",             1'b1, 64'h1234_5678, 1'b0, 6, 0, 0);
    run("R6 ctx reserved",         1'b1, 64'h1234_5678, 1'b0, 7, 1, 0);
    run("R5 level1 invalid",       1'b1, 64'h0000_1000, 1'b0, 3, 0, 0);
    run("R6 level1 reserved",      1'b1, 64'h4100_0000, 1'b0, 3, 0, 0);
    run("R6 level2 reserved",      1'b1, 64'h4004_0000, 1'b0, 3, 2, 0);
    run("R6 level3 pointer",       1'b1, 64'h4000_9000, 1'b0, 3, 0, 0);
    run("R5 level3 invalid",       1'b1, 64'h4000_A000, 1'b1, 3, 0, 1);
    run("R10 slow memory walk",    1'b1, 64'h4000_5000, 1'b0, 3, 5, 0);
    run("R1 bypass again",         1'b0, 64'h0000_0004, 1'b0, 3, 0, 0);

    mon_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule